// File: doc/BRIEF.md
# Clock Synthesizer Mode and Strap Controller

This block sits in front of the output stage of a system clock synthesizer. It reads two static mode pins and decodes the operating mode from them. The frequency-select pin chooses the CPU rate. The active-low test/tristate pin chooses between normal operation and the special modes. A reserved configuration field is also decoded, and any non-zero value in it is flagged as an illegal mode.

The block produces the CPU, PCI and reference clock outputs, one output enable per group, and a line that tells the PLL to use the fast CPU rate. In normal operation the CPU and PCI outputs pass through the PLL clocks. In test mode the PLL clocks are replaced by integer divisions of the block's own input clock, which is then the externally applied test clock.

At power-on the block samples two strap pins once. These pins are later reused as reference-clock outputs, so the reference output enable stays low until the sample has been taken. One strap selects spread-spectrum operation. The other strap decides whether the dual-frequency output carries the 48 MHz input unchanged or divided by two.

Top module: `clksyn_mode_ctrl`

## Requirements
- R1: With `cfg_rsvd` = 0 and `ts_n` = 1 the mode is active. `cpu_clk_o` follows `pll_cpu_clk` and `pci_clk_o` follows `pll_pci_clk`. `cpu_fast` equals `freq_sel` (1 = 100 MHz CPU, 0 = 66.6 MHz CPU). `cpu_oe` and `pci_oe` are high. The PCI output does not depend on `freq_sel`.
- R2: With `cfg_rsvd` = 0, `ts_n` = 0 and `freq_sel` = 0, the outputs are in tristate: `cpu_oe`, `pci_oe` and `ref_oe` are low, and `cpu_clk_o`, `pci_clk_o` and `ref_clk_o` are 0.
- R3: With `cfg_rsvd` = 0, `ts_n` = 0 and `freq_sel` = 1, the block is in test mode. `cpu_clk_o` is `clk_in` divided by 2 and `pci_clk_o` is `clk_in` divided by 6 (high for 3 cycles, low for 3 cycles). `ref_clk_o` equals `clk_in`, and `cpu_fast` is 0.
- R4: Both test-mode dividers are held cleared outside test mode. Both dividers go high on the first `clk_in` rising edge in test mode. Every rising edge of the PCI divider coincides with a rising edge of the CPU divider.
- R5: Any non-zero `cfg_rsvd` is a reserved mode. In a reserved mode `mode_error` is 1, all three clock outputs are 0, and all three output enables are 1 (the outputs are driven low). Otherwise `mode_error` is 0.
- R6: On the first `clk_in` rising edge after `rst_n` deasserts, the block captures `strap_spread_n` and `strap_sel24`. After the capture, `spread_en` equals the inverse of the captured spread strap and `sel_24m` equals the captured select strap. Before the capture, both outputs are 0.
- R7: After the capture, changes on the strap pins have no effect on `spread_en` or `sel_24m` until the next reset.
- R8: `ref_oe` stays low until the strap capture has taken place, and is high afterwards in every mode except tristate.
- R9: `dual_clk_o` equals `clk48_in` when `sel_24m` = 0. When `sel_24m` = 1 it toggles on each rising edge of `clk48_in`, which gives 24 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference / test clock |
| clk48_in | input | 1 | 48 MHz source clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| freq_sel | input | 1 | CPU frequency select |
| ts_n | input | 1 | Tristate/test select, active low |
| cfg_rsvd | input | RSVD_W | Reserved mode bits, must be 0 |
| strap_spread_n | input | 1 | Spread strap pin, low = spread on |
| strap_sel24 | input | 1 | Dual-output strap pin, high = 24 MHz |
| pll_cpu_clk | input | 1 | CPU clock from PLL |
| pll_pci_clk | input | 1 | PCI clock from PLL |
| cpu_clk_o | output | 1 | CPU clock output |
| pci_clk_o | output | 1 | PCI clock output |
| ref_clk_o | output | 1 | Reference clock output |
| cpu_oe | output | 1 | CPU output enable |
| pci_oe | output | 1 | PCI output enable |
| ref_oe | output | 1 | Reference output enable |
| cpu_fast | output | 1 | PLL request for the 100 MHz CPU rate |
| spread_en | output | 1 | Spread-spectrum enable |
| sel_24m | output | 1 | Dual output at 24 MHz |
| dual_clk_o | output | 1 | 48/24 MHz output |
| mode_error | output | 1 | Reserved mode decoded |

## Verification
The decode is exercised with all four combinations of `freq_sel` and `ts_n`, and then with a non-zero reserved field laid over both a test and an active encoding. This shows that the reserved field overrides the pins. The PLL inputs are driven to opposite static levels in the active mode. This tells a pass-through apart from a swapped or constant output, and it confirms that `freq_sel` moves `cpu_fast` but not the PCI path. Test mode is entered from active mode and traced edge by edge over two full PCI periods, which exposes wrong division ratios, wrong phase, and a missing clear. The straps are captured across two resets with opposite pin values. After each capture the pins are toggled, which separates a one-time latch from a transparent one.

// File: rtl/clksyn_mode_ctrl.sv
module clksyn_mode_ctrl #(
  parameter int CPU_DIV = 2,
  parameter int PCI_DIV = 6,
  parameter int RSVD_W  = 1
) (
  input  logic              clk_in,
  input  logic              clk48_in,
  input  logic              rst_n,
  input  logic              freq_sel,
  input  logic              ts_n,
  input  logic [RSVD_W-1:0] cfg_rsvd,
  input  logic              strap_spread_n,
  input  logic              strap_sel24,
  input  logic              pll_cpu_clk,
  input  logic              pll_pci_clk,
  output logic              cpu_clk_o,
  output logic              pci_clk_o,
  output logic              ref_clk_o,
  output logic              cpu_oe,
  output logic              pci_oe,
  output logic              ref_oe,
  output logic              cpu_fast,
  output logic              spread_en,
  output logic              sel_24m,
  output logic              dual_clk_o,
  output logic              mode_error
);

  localparam int MAXDIV = (CPU_DIV > PCI_DIV) ? CPU_DIV : PCI_DIV;
  localparam int DW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;
  localparam int NDIV   = 2;

  logic rsvd, m_tri, m_test, m_act;
  assign rsvd   = (cfg_rsvd != '0);
  assign m_tri  = !rsvd && !ts_n && !freq_sel;
  assign m_test = !rsvd && !ts_n && freq_sel;
  assign m_act  = !rsvd && ts_n;

  logic [NDIV-1:0] div_q;

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    localparam int DV = (g == 0) ? CPU_DIV : PCI_DIV;
    localparam logic [DW-1:0] LAST = DW'(DV - 1);
    localparam logic [DW-1:0] HALF = DW'(DV / 2);
    logic [DW-1:0] ph;
    always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
        ph       <= '0;
        div_q[g] <= 1'b0;
      end else if (!m_test) begin
        ph       <= '0;
        div_q[g] <= 1'b0;
      end else begin
        ph       <= (ph == LAST) ? '0 : ph + 1'b1;
        div_q[g] <= (ph < HALF);
      end
    end
  end

  logic cap_done, spread_n_q, sel24_q;
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cap_done   <= 1'b0;
      spread_n_q <= 1'b1;
      sel24_q    <= 1'b0;
    end else if (!cap_done) begin
      cap_done   <= 1'b1;
      spread_n_q <= strap_spread_n;
      sel24_q    <= strap_sel24;
    end
  end

  logic half48_q;
  always_ff @(posedge clk48_in or negedge rst_n) begin
    if (!rst_n) half48_q <= 1'b0;
    else        half48_q <= ~half48_q;
  end

  assign spread_en  = cap_done & ~spread_n_q;
  assign sel_24m    = sel24_q;
  assign dual_clk_o = sel24_q ? half48_q : clk48_in;

  assign cpu_clk_o  = m_act ? pll_cpu_clk : (m_test & div_q[0]);
  assign pci_clk_o  = m_act ? pll_pci_clk : (m_test & div_q[1]);
  assign ref_clk_o  = (m_act | m_test) & clk_in;
  assign cpu_oe     = !m_tri;
  assign pci_oe     = !m_tri;
  assign ref_oe     = !m_tri & cap_done;
  assign cpu_fast   = m_act & freq_sel;
  assign mode_error = rsvd;

endmodule

// File: rtl/clksyn_mode_ctrl_chk.sv
module clksyn_mode_ctrl_chk #(
  parameter int RSVD_W = 1
) (
  input logic              clk_in,
  input logic              rst_n,
  input logic              freq_sel,
  input logic              ts_n,
  input logic [RSVD_W-1:0] cfg_rsvd,
  input logic              cpu_clk_o,
  input logic              pci_clk_o,
  input logic              cpu_oe,
  input logic              pci_oe,
  input logic              ref_oe,
  input logic              spread_en,
  input logic              sel_24m,
  input logic              mode_error
);

  logic [1:0] cyc;
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 1'b1;
  end

  logic test_in;
  assign test_in = (cfg_rsvd == '0) && !ts_n && freq_sel;

  p_tristate_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    ((cfg_rsvd == '0) && !ts_n && !freq_sel) |->
      (!cpu_oe && !pci_oe && !ref_oe && !cpu_clk_o && !pci_clk_o));

  p_reserved_low_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cfg_rsvd != '0) |-> (mode_error && !cpu_clk_o && !pci_clk_o && cpu_oe && pci_oe));

  p_div_align_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    ((cyc != 0) && test_in && $past(test_in) && $rose(pci_clk_o)) |-> $rose(cpu_clk_o));

  p_strap_frozen_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cyc >= 2) |-> ($stable(spread_en) && $stable(sel_24m)));

  p_ref_hold_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cyc == 0) |-> !ref_oe);

endmodule

bind clksyn_mode_ctrl clksyn_mode_ctrl_chk #(.RSVD_W(RSVD_W)) u_chk (.*);

// File: tb/clksyn_mode_ctrl_tb.sv
module clksyn_mode_ctrl_tb;
  logic clk_in = 0, clk48_in = 0, rst_n = 0;
  logic freq_sel = 0, ts_n = 1;
  logic [0:0] cfg_rsvd = '0;
  logic strap_spread_n = 1, strap_sel24 = 0, pll_cpu_clk = 0, pll_pci_clk = 0;
  logic cpu_clk_o, pci_clk_o, ref_clk_o, cpu_oe, pci_oe, ref_oe;
  logic cpu_fast, spread_en, sel_24m, dual_clk_o, mode_error;
  int n_run = 0, n_fail = 0;

  always #2 clk_in = ~clk_in;
  always #5 clk48_in = ~clk48_in;

  clksyn_mode_ctrl u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic sp_n, input logic s24);
    @(negedge clk_in);
    rst_n = 0; strap_spread_n = sp_n; strap_sel24 = s24;
    cfg_rsvd = '0; ts_n = 1; freq_sel = 0;
    #7;
    @(negedge clk_in);
    rst_n = 1;
    #1;
    chk("R8 ref_oe before capture", ref_oe, 1'b0);
    chk("R6 spread_en before capture", spread_en, 1'b0);
    chk("R6 sel_24m before capture", sel_24m, 1'b0);
    @(posedge clk_in); #1;
    chk("R6 spread_en captured", spread_en, ~sp_n);
    chk("R6 sel_24m captured", sel_24m, s24);
    chk("R8 ref_oe after capture", ref_oe, 1'b1);
    @(negedge clk_in);
    strap_spread_n = ~sp_n; strap_sel24 = ~s24;
    repeat (3) @(posedge clk_in);
    #1;
    chk("R7 spread_en frozen", spread_en, ~sp_n);
    chk("R7 sel_24m frozen", sel_24m, s24);
  endtask

  task automatic t_active();
    for (int f = 0; f < 2; f++) begin
      @(negedge clk_in);
      cfg_rsvd = '0; ts_n = 1; freq_sel = f[0];
      pll_cpu_clk = 1; pll_pci_clk = 0;
      #1;
      chk("R1 cpu follows pll", cpu_clk_o, 1'b1);
      chk("R1 pci follows pll", pci_clk_o, 1'b0);
      chk("R1 cpu_fast", cpu_fast, f[0]);
      chk("R1 oe", cpu_oe & pci_oe, 1'b1);
      chk("R5 no error", mode_error, 1'b0);
      pll_cpu_clk = 0; pll_pci_clk = 1;
      #1;
      chk("R1 cpu follows pll low", cpu_clk_o, 1'b0);
      chk("R1 pci independent of freq_sel", pci_clk_o, 1'b1);
    end
  endtask

  task automatic t_tristate();
    @(negedge clk_in);
    cfg_rsvd = '0; ts_n = 0; freq_sel = 0; pll_cpu_clk = 1; pll_pci_clk = 1;
    @(posedge clk_in); #1;
    chk("R2 cpu_oe", cpu_oe, 1'b0);
    chk("R2 pci_oe", pci_oe, 1'b0);
    chk("R2 ref_oe", ref_oe, 1'b0);
    chk("R2 outputs low", cpu_clk_o | pci_clk_o | ref_clk_o, 1'b0);
  endtask

  task automatic t_test();
    @(negedge clk_in);
    cfg_rsvd = '0; ts_n = 1; freq_sel = 1;
    @(negedge clk_in);
    ts_n = 0;
    #1;
    chk("R4 cpu div cleared at entry", cpu_clk_o, 1'b0);
    chk("R4 pci div cleared at entry", pci_clk_o, 1'b0);
    chk("R3 ref low in clk low phase", ref_clk_o, 1'b0);
    chk("R3 cpu_fast low in test", cpu_fast, 1'b0);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk_in); #1;
      chk("R3 cpu div2", cpu_clk_o, (i % 2) == 0);
      chk("R3 pci div6", pci_clk_o, (i % 6) < 3);
      if (i == 0) chk("R3 ref follows clk", ref_clk_o, 1'b1);
    end
  endtask

  task automatic t_reserved();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk_in);
      cfg_rsvd = 1'b1; ts_n = k[0]; freq_sel = 1; pll_cpu_clk = 1; pll_pci_clk = 1;
      @(posedge clk_in); #1;
      chk("R5 mode_error", mode_error, 1'b1);
      chk("R5 outputs low", cpu_clk_o | pci_clk_o | ref_clk_o, 1'b0);
      chk("R5 outputs driven", cpu_oe & pci_oe & ref_oe, 1'b1);
    end
    @(negedge clk_in);
    cfg_rsvd = '0; ts_n = 1;
  endtask

  task automatic t_dual(input logic s24);
    logic prev;
    @(posedge clk48_in); #1;
    if (!s24) begin
      chk("R9 dual 48 high", dual_clk_o, 1'b1);
      @(negedge clk48_in); #1;
      chk("R9 dual 48 low", dual_clk_o, 1'b0);
    end else begin
      prev = dual_clk_o;
      for (int i = 0; i < 4; i++) begin
        @(posedge clk48_in); #1;
        chk("R9 dual 24 toggles", dual_clk_o, ~prev);
        @(negedge clk48_in); #1;
        chk("R9 dual 24 holds", dual_clk_o, ~prev);
        prev = ~prev;
      end
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    do_reset(1'b0, 1'b0);
    t_dual(1'b0);
    t_active();
    t_test();
    t_tristate();
    t_reserved();
    t_test();
    do_reset(1'b1, 1'b1);
    chk("R6 spread off when strap high", spread_en, 1'b0);
    t_dual(1'b1);
    t_active();
    finish_up();
  end
endmodule